// File: doc/BRIEF.md
# Sprite XOR Draw Engine

This block draws one sprite into a 64 by 32 monochrome frame buffer. A start pulse hands it a column, a line, a row count and a base address. It then walks the sprite one row at a time. For each row it reads one byte from sprite memory. For every set bit in that byte it performs a single-pixel read-modify-write on the frame buffer, inverting the stored pixel. Coordinates that run past the right or bottom edge continue on the opposite side of the screen. When the last pixel has been handled the block pulses `done`. On that cycle it presents a collision flag, which tells the caller whether any lit pixel was switched off during the draw.

Both external ports are simple synchronous reads with one cycle of latency. The sprite memory returns a byte on the cycle after `mem_rd`. The frame buffer returns a bit on the cycle after `fb_rd` and accepts a write on `fb_we`. The engine only ever raises one of these three strobes in a given cycle. A caller issues a draw, waits for `done`, samples `collision` and can then start the next draw.

Top module: `sprite_xor_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `collision`, `mem_rd`, `fb_rd` and `fb_we` are all 0.
- R2: Sprite row r is fetched with exactly one `mem_rd` at address (`sprite_base` + r) modulo 4096. Rows are fetched in order r = 0 .. N-1, and the byte is taken from `mem_data` on the cycle after `mem_rd`.
- R3: Row r is drawn on line `y_pos` + r. Sprite bit 7 lands on column `x_pos`, and bit 0 lands on column `x_pos` + 7.
- R4: Each set sprite bit causes one `fb_rd`, followed on the very next cycle by one `fb_we` to the same `fb_addr`. The write carries the inverse of the bit read back on `fb_rdata`. Frame address = line * 64 + column: line in bits [10:6], column in bits [5:0].
- R5: A sprite bit that is 0 causes no frame-buffer read or write, so that pixel keeps its value.
- R6: Columns wrap modulo 64 and lines wrap modulo 32.
- R7: `collision` is 1 when at least one pixel read back as 1 was rewritten to 0 during the draw, and 0 otherwise. It is cleared when a draw is accepted and holds its value while the engine is idle.
- R8: `done` is high for exactly one cycle. It rises 1 + 10*N + P cycles after the cycle in which `start` is sampled, where P is the number of set bits across the N sprite bytes.
- R9: A `start` that arrives while `busy` is high is ignored. The draw in progress finishes with its original operands, and no second draw follows.
- R10: A row count of 0 reads no memory and touches no pixel. `done` rises on the cycle after start, with `collision` at 0.
- R11: An all-zero sprite byte costs one fetch and eight scan cycles, and makes no frame-buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a draw (accepted only when idle) |
| x_pos | input | 6 | Left column of the sprite |
| y_pos | input | 5 | Top line of the sprite |
| row_cnt | input | 4 | Number of sprite rows N |
| sprite_base | input | 12 | Memory address of row 0 |
| mem_rd | output | 1 | Sprite memory read strobe |
| mem_addr | output | 12 | Sprite memory address |
| mem_data | input | 8 | Sprite byte, valid the cycle after `mem_rd` |
| fb_rd | output | 1 | Frame-buffer read strobe |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | 11 | Frame-buffer pixel address |
| fb_rdata | input | 1 | Pixel value, valid the cycle after `fb_rd` |
| fb_wdata | output | 1 | Pixel value to write |
| busy | output | 1 | A draw is in progress (including the `done` cycle) |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | Lit pixel was cleared during the last draw |

## Verification
The bench places sprites across both the right and the bottom edges, and starts one from address 0xFFE. A design that clipped instead of wrapping, or that carried the column overflow into the line field, would leave pixels in the wrong place. A base address that failed to wrap would fetch the wrong bytes. Drawing the same sprite twice must report a collision and restore the screen exactly. A design that set the flag on untouched pixels, or that wrote sprite zeros, would show up as a stray flag or stray frame writes. The bench also draws single-bit patterns to pin down bit order, tries a zero row count and all-zero rows, and raises start in the middle of a draw. An engine that restarted on that pulse would produce the second operands' pixels and a wrong completion time.

// File: rtl/sprite_xor_pkg.sv
package sprite_xor_pkg;

  // Control states of the draw sequencer
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for start
    ST_FETCH,  // sprite byte read issued
    ST_LATCH,  // sprite byte captured
    ST_PIX,    // examine one sprite bit, read pixel if set
    ST_WR,     // write back the inverted pixel
    ST_DONE    // completion pulse
  } draw_state_t;

endpackage

// File: rtl/sprite_row_fetch.sv
module sprite_row_fetch #(
  parameter int ADDR_BITS = 12,
  parameter int N_BITS    = 4,
  parameter int SPR_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [ADDR_BITS-1:0] base_in,
  input  logic [N_BITS-1:0]    rows_in,
  input  logic                 step_row,
  input  logic                 capture,
  input  logic [SPR_W-1:0]     mem_data,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [N_BITS-1:0]    row_idx,
  output logic                 last_row,
  output logic                 zero_rows,
  output logic [SPR_W-1:0]     sprite_row
);

  logic [ADDR_BITS-1:0] base_q;
  logic [N_BITS-1:0]    rows_q;
  logic [N_BITS-1:0]    row_q;
  logic [SPR_W-1:0]     spr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      rows_q <= '0;
      row_q  <= '0;
      spr_q  <= '0;
    end else begin
      if (load) begin
        base_q <= base_in;
        rows_q <= rows_in;
        row_q  <= '0;
      end else if (step_row) begin
        row_q <= row_q + N_BITS'(1);
      end
      if (capture) spr_q <= mem_data;
    end
  end

  // Address arithmetic wraps naturally at the memory size
  assign mem_addr   = base_q + ADDR_BITS'(row_q);
  assign row_idx    = row_q;
  assign last_row   = (row_q == rows_q - N_BITS'(1));
  assign zero_rows  = (rows_in == '0);
  assign sprite_row = spr_q;

  // The row counter never runs past the requested row count
  assert_row_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (rows_q != '0) |-> (row_q < rows_q));

  // A row step is only legal once a row has finished, never on a reload
  assert_step_not_load_R9: assert property (@(posedge clk) disable iff (rst)
    step_row |-> !load);

endmodule

// File: rtl/sprite_pix_addr.sv
module sprite_pix_addr #(
  parameter int X_BITS   = 6,
  parameter int Y_BITS   = 5,
  parameter int N_BITS   = 4,
  parameter int COL_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [X_BITS-1:0]        x_in,
  input  logic [Y_BITS-1:0]        y_in,
  input  logic [N_BITS-1:0]        row_idx,
  input  logic [COL_BITS-1:0]      col_idx,
  output logic [X_BITS+Y_BITS-1:0] fb_addr
);

  logic [X_BITS-1:0] x_q;
  logic [Y_BITS-1:0] y_q;
  logic [X_BITS-1:0] col_abs;
  logic [Y_BITS-1:0] line_abs;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= x_in;
      y_q <= y_in;
    end
  end

  // Power-of-two screen: truncating adds give the edge wrap
  assign col_abs  = x_q + X_BITS'(col_idx);
  assign line_abs = y_q + Y_BITS'(row_idx);
  assign fb_addr  = {line_abs, col_abs};

endmodule

// File: rtl/sprite_draw_ctrl.sv
module sprite_draw_ctrl
  import sprite_xor_pkg::*;
#(
  parameter int SPR_W    = 8,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                zero_rows,
  input  logic                last_row,
  input  logic [SPR_W-1:0]    sprite_row,
  input  logic                fb_rdata,
  output logic                load,
  output logic                issue,
  output logic                capture,
  output logic                step_row,
  output logic                fb_rd,
  output logic                fb_we,
  output logic                fb_wdata,
  output logic [COL_BITS-1:0] col,
  output logic                busy,
  output logic                done,
  output logic                collision
);

  localparam logic [COL_BITS-1:0] COL_LAST = COL_BITS'(SPR_W - 1);

  draw_state_t         state_q, state_d;
  logic [COL_BITS-1:0] col_q;
  logic                coll_q;
  logic                pix_on;
  logic                col_last;
  logic                advance;

  // Bit 7 of the sprite byte is the leftmost column
  assign pix_on   = sprite_row[(SPR_W - 1) - int'(col_q)];
  assign col_last = (col_q == COL_LAST);
  assign advance  = ((state_q == ST_PIX) && !pix_on) || (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = zero_rows ? ST_DONE : ST_FETCH;
      ST_FETCH: state_d = ST_LATCH;
      ST_LATCH: state_d = ST_PIX;
      ST_PIX: begin
        if (pix_on)        state_d = ST_WR;
        else if (col_last) state_d = last_row ? ST_DONE : ST_FETCH;
      end
      ST_WR: begin
        if (col_last) state_d = last_row ? ST_DONE : ST_FETCH;
        else          state_d = ST_PIX;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LATCH)        col_q <= '0;
      else if (advance && !col_last)  col_q <= col_q + COL_BITS'(1);
      if (load)                               coll_q <= 1'b0;
      else if ((state_q == ST_WR) && fb_rdata) coll_q <= 1'b1;
    end
  end

  assign load      = start && (state_q == ST_IDLE);
  assign issue     = (state_q == ST_FETCH);
  assign capture   = (state_q == ST_LATCH);
  assign step_row  = advance && col_last && !last_row;
  assign fb_rd     = (state_q == ST_PIX) && pix_on;
  assign fb_we     = (state_q == ST_WR);
  assign fb_wdata  = ~fb_rdata;
  assign col       = col_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign collision = coll_q;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> $past(fb_rd));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue, fb_rd, fb_we}));

  assert_single_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    issue |=> !issue);

  assert_coll_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(collision));

  assert_stay_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: rtl/sprite_xor_engine.sv
module sprite_xor_engine #(
  parameter int X_BITS    = 6,
  parameter int Y_BITS    = 5,
  parameter int N_BITS    = 4,
  parameter int ADDR_BITS = 12,
  parameter int SPR_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [X_BITS-1:0]        x_pos,
  input  logic [Y_BITS-1:0]        y_pos,
  input  logic [N_BITS-1:0]        row_cnt,
  input  logic [ADDR_BITS-1:0]     sprite_base,
  output logic                     mem_rd,
  output logic [ADDR_BITS-1:0]     mem_addr,
  input  logic [SPR_W-1:0]         mem_data,
  output logic                     fb_rd,
  output logic                     fb_we,
  output logic [X_BITS+Y_BITS-1:0] fb_addr,
  input  logic                     fb_rdata,
  output logic                     fb_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     collision
);

  localparam int COL_BITS = (SPR_W > 1) ? $clog2(SPR_W) : 1;

  logic                load;
  logic                capture;
  logic                step_row;
  logic                last_row;
  logic                zero_rows;
  logic [N_BITS-1:0]   row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [SPR_W-1:0]    sprite_row;

  sprite_row_fetch #(
    .ADDR_BITS(ADDR_BITS), .N_BITS(N_BITS), .SPR_W(SPR_W)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .base_in    (sprite_base),
    .rows_in    (row_cnt),
    .step_row   (step_row),
    .capture    (capture),
    .mem_data   (mem_data),
    .mem_addr   (mem_addr),
    .row_idx    (row_idx),
    .last_row   (last_row),
    .zero_rows  (zero_rows),
    .sprite_row (sprite_row)
  );

  sprite_pix_addr #(
    .X_BITS(X_BITS), .Y_BITS(Y_BITS), .N_BITS(N_BITS), .COL_BITS(COL_BITS)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .x_in    (x_pos),
    .y_in    (y_pos),
    .row_idx (row_idx),
    .col_idx (col_idx),
    .fb_addr (fb_addr)
  );

  sprite_draw_ctrl #(
    .SPR_W(SPR_W), .COL_BITS(COL_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .zero_rows  (zero_rows),
    .last_row   (last_row),
    .sprite_row (sprite_row),
    .fb_rdata   (fb_rdata),
    .load       (load),
    .issue      (mem_rd),
    .capture    (capture),
    .step_row   (step_row),
    .fb_rd      (fb_rd),
    .fb_we      (fb_we),
    .fb_wdata   (fb_wdata),
    .col        (col_idx),
    .busy       (busy),
    .done       (done),
    .collision  (collision)
  );

  // Read-modify-write stays on one pixel
  assert_rmw_same_pixel_R4: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (fb_addr == $past(fb_addr)));

  // Nothing reaches either memory outside a draw
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || fb_rd || fb_we));

endmodule

// File: tb/sprite_xor_engine_bench.sv
`timescale 1ns/1ps
module sprite_xor_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  x_pos = '0;
  logic [4:0]  y_pos = '0;
  logic [3:0]  row_cnt = '0;
  logic [11:0] sprite_base = '0;
  logic        mem_rd;
  logic [11:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic        fb_rd, fb_we, fb_wdata;
  logic [10:0] fb_addr;
  logic        fb_rdata = 1'b0;
  logic        busy, done, collision;

  logic [7:0]  mem_m  [4096];
  logic        fb_m   [2048];
  logic        exp_fb [2048];
  int          cyc = 0;

  always #2.5 clk = ~clk;

  sprite_xor_engine u_sprite_xor_engine (
    .clk(clk), .rst(rst), .start(start), .x_pos(x_pos), .y_pos(y_pos),
    .row_cnt(row_cnt), .sprite_base(sprite_base), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .fb_rd(fb_rd), .fb_we(fb_we),
    .fb_addr(fb_addr), .fb_rdata(fb_rdata), .fb_wdata(fb_wdata),
    .busy(busy), .done(done), .collision(collision)
  );

  // Memory and frame-buffer models, one cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_data <= mem_m[mem_addr];
    if (rst) begin
      for (int i = 0; i < 2048; i++) fb_m[i] <= 1'b0;
    end else begin
      if (fb_rd) fb_rdata <= fb_m[fb_addr];
      if (fb_we) fb_m[fb_addr] <= fb_wdata;
    end
  end

  int vectors = 0;
  int miscompares = 0;
  int q_addr [$];
  int q_coll [$];
  int q_lat  [$];
  int q_pop  [$];
  int q_rows [$];
  int start_cyc, rd_cnt, wr_cnt, last_rd_addr;
  bit draw_done, done_prev;
  int last_coll;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Monitor: pops expected items and compares as results appear
  task automatic monitor_loop();
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (mem_rd) begin
          rd_cnt++;
          if (q_addr.size() == 0) chk(1'b0, "R2 unexpected fetch", int'(mem_addr), -1);
          else begin
            int e = q_addr.pop_front();
            chk(int'(mem_addr) == e, "R2 fetch address", int'(mem_addr), e);
          end
        end
        if (fb_rd) last_rd_addr = int'(fb_addr);
        if (fb_we) begin
          wr_cnt++;
          chk(int'(fb_addr) == last_rd_addr, "R4 write address", int'(fb_addr), last_rd_addr);
          chk(fb_wdata == !fb_m[fb_addr], "R4 write data", int'(fb_wdata), int'(!fb_m[fb_addr]));
        end
        chk(!(done && done_prev), "R8 done width", int'(done && done_prev), 0);
        if (done) begin
          int ec = q_coll.pop_front();
          int el = q_lat.pop_front();
          int ep = q_pop.pop_front();
          int en = q_rows.pop_front();
          int mm = 0;
          chk(int'(collision) == ec, "R7 collision", int'(collision), ec);
          chk(cyc - start_cyc == el, "R8 done latency", cyc - start_cyc, el);
          chk(wr_cnt == ep, "R5 pixel writes", wr_cnt, ep);
          chk(rd_cnt == en, "R2 fetch count", rd_cnt, en);
          for (int i = 0; i < 2048; i++) if (fb_m[i] !== exp_fb[i]) mm++;
          chk(mm == 0, "R3 R6 frame contents", mm, 0);
          last_coll = ec;
          draw_done = 1'b1;
        end
        done_prev = done;
      end
    end
  endtask

  // Driver: computes expectations, then issues the draw
  task automatic draw(input int x, input int y, input int n, input int base, input bit inject);
    int coll = 0;
    int pop = 0;
    for (int r = 0; r < n; r++) begin
      int a = (base + r) & 12'hFFF;
      logic [7:0] b = mem_m[a];
      q_addr.push_back(a);
      for (int c = 0; c < 8; c++) begin
        if (b[7-c]) begin
          int idx = (((y + r) % 32) * 64) + ((x + c) % 64);
          pop++;
          if (exp_fb[idx]) coll = 1;
          exp_fb[idx] = !exp_fb[idx];
        end
      end
    end
    q_coll.push_back(coll);
    q_lat.push_back(1 + 10*n + pop);
    q_pop.push_back(pop);
    q_rows.push_back(n);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; draw_done = 1'b0;
    x_pos = 6'(x); y_pos = 5'(y); row_cnt = 4'(n); sprite_base = 12'(base);
    start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      x_pos = 6'd3; y_pos = 5'd9; row_cnt = 4'd2; sprite_base = 12'h020;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!draw_done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_m[i] = 8'((i * 29 + 7) & 255);
    for (int i = 0; i < 2048; i++) exp_fb[i] = 1'b0;
    fork
      begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    // R1: reset state while reset is held
    chk(!busy && !done && !collision, "R1 status in reset", int'({busy, done, collision}), 0);
    chk(!mem_rd && !fb_rd && !fb_we, "R1 strobes in reset", int'({mem_rd, fb_rd, fb_we}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !collision, "R1 status after reset", int'({busy, done, collision}), 0);
    fork monitor_loop(); join_none

    // R3: bit order, single pixels at both ends of a byte
    mem_m[12'h200] = 8'h80; mem_m[12'h201] = 8'h01;
    draw(0, 0, 2, 12'h200, 1'b0);
    // Generic sprite, mixed bytes
    mem_m[12'h100] = 8'hF0; mem_m[12'h101] = 8'h90; mem_m[12'h102] = 8'hF0;
    mem_m[12'h103] = 8'h90; mem_m[12'h104] = 8'h90;
    draw(10, 5, 5, 12'h100, 1'b0);
    // R7: redraw over itself sets collision and restores the screen
    draw(10, 5, 5, 12'h100, 1'b0);
    repeat (5) @(negedge clk);
    chk(int'(collision) == last_coll, "R7 hold while idle", int'(collision), last_coll);
    // R6: wrap past right and bottom edges
    mem_m[12'h300] = 8'hFF; mem_m[12'h301] = 8'hA5; mem_m[12'h302] = 8'h3C; mem_m[12'h303] = 8'hFF;
    draw(60, 30, 4, 12'h300, 1'b0);
    // R7: partial overlap of the wrapped sprite
    mem_m[12'h310] = 8'h0F;
    draw(62, 31, 1, 12'h310, 1'b0);
    // R2: base address wraps around memory top
    mem_m[12'hFFE] = 8'hC3; mem_m[12'hFFF] = 8'h18; mem_m[12'h000] = 8'h81; mem_m[12'h001] = 8'h7E;
    draw(20, 12, 4, 12'hFFE, 1'b0);
    // R10: zero rows after a colliding draw
    draw(20, 12, 4, 12'hFFE, 1'b0);
    draw(5, 5, 0, 12'h100, 1'b0);
    chk(int'(collision) == 0, "R10 collision cleared", int'(collision), 0);
    // R11: all-zero rows
    mem_m[12'h400] = 8'h00; mem_m[12'h401] = 8'h00; mem_m[12'h402] = 8'h00;
    draw(30, 16, 3, 12'h400, 1'b0);
    // R9: start pulse during a draw is ignored
    draw(40, 8, 6, 12'h500, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy, "R9 no second draw", int'(busy), 0);
    chk(q_addr.size() == 0, "R9 no extra fetch", q_addr.size(), 0);
    // Tallest sprite
    draw(33, 20, 15, 12'h600, 1'b0);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule